// File: doc/BRIEF.md
# Message-Based Interrupt Controller

This block carries interrupts between agents on a shared system bus as four-byte messages instead of dedicated wires. A local processor assembles an outgoing message through a small 8-bit register port: one byte each for the source, the destination and the type, plus a fourth byte. Writing the last byte starts the send. The block asks a bus-access controller for the bus and waits for the grant. It then drives a one-cycle address phase carrying the destination, followed by a data phase carrying the whole message. The data phase is held until the bus signals ready.

On the receiving side the block watches every address phase on the multiplexed address/data bus. When the address equals its own programmable message address, it asserts a select toward the bus-access controller and captures the following data word into a four-entry queue. A level interrupt tells the processor that messages are waiting. The processor drains each message one byte at a time through a single data register, and the fourth byte read removes the message from the queue. A status register reports the queue fill, whether a send is in progress, and a sticky flag that records messages lost because the queue was full.

Top module: `msg_irq_ctrl`

## Requirements
- R1: Registers 0 to 3 hold the outgoing message bytes (byte 0 least significant) and read back as written. Writes to bytes 0 to 2 leave `bus_req` low. A write to register 3 raises `bus_req` in the cycle after the write is accepted.
- R2: After a send starts, `bus_req` stays high with no bus phase driven until `bus_gnt` is seen. The next cycle is a single address phase: `adr_strb_out` and `ad_oe` are high and `ad_out` equals byte 1 zero-extended to 32 bits. Then comes the data phase: `dat_strb_out` and `ad_oe` are high and `ad_out` equals `{byte3,byte2,byte1,byte0}`, held stable until `bus_rdy`. In the cycle after `bus_rdy`, `bus_req`, `ad_oe` and both strobes are low.
- R3: A host access is active while `cs_n` is low and either `wr_n` or `rd_n` is low. It takes effect exactly once, on its first clock edge. `wait_n` is low from the start of the access until that edge, and `rdata` is valid once `wait_n` is high.
- R4: A write to registers 0 to 3 while a send is in progress holds `wait_n` low and is not performed. It completes on the first edge after the send ends and does not start a new send unless it targets register 3.
- R5: An address phase (`adr_strb_in` high) with `ad_in` equal to the own address zero-extended to 32 bits raises `bus_sel` in the next cycle. `bus_sel` stays high until `dat_strb_in`, and the data word on `ad_in` in that cycle is queued.
- R6: An address phase with any other value on `ad_in` raises no select and queues nothing.
- R7: The queue holds four messages in arrival order. Reads of register 4 return the head message least significant byte first, and the fourth read removes it. A read of register 4 with an empty queue returns 0 and changes nothing.
- R8: `msg_irq` is high exactly while the queue holds at least one message. It falls after the read that removes the last one.
- R9: The status register (5) reads bits [2:0] as the queue count, bit 3 as send in progress, bit 4 as the overflow flag, and bits [7:5] as zero. A matching address phase while the queue is full raises no select, queues nothing and sets the overflow flag. The flag stays set until a status read, which returns it set and clears it.
- R10: Register 6 holds the own message address and reads back as written. Register 7 reads as 0, and writes to it have no effect.
- R11: After reset, `wait_n` is high, `msg_irq`, `bus_req`, `bus_sel`, `ad_oe` and both output strobes are low, and status and the own address read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| reg_addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| wait_n | output | 1 | Host wait request, active low |
| msg_irq | output | 1 | Message pending interrupt |
| bus_req | output | 1 | Bus request to access controller |
| bus_gnt | input | 1 | Bus grant from access controller |
| bus_rdy | input | 1 | Data phase ready from access controller |
| bus_sel | output | 1 | Select to access controller as receiver |
| ad_in | input | 32 | Multiplexed address/data bus, incoming |
| adr_strb_in | input | 1 | Incoming address phase marker |
| dat_strb_in | input | 1 | Incoming data phase marker |
| ad_out | output | 32 | Multiplexed address/data bus, outgoing |
| ad_oe | output | 1 | Output enable for `ad_out` |
| adr_strb_out | output | 1 | Outgoing address phase marker |
| dat_strb_out | output | 1 | Outgoing data phase marker |

## Verification
The hardest situation to reach is a host write to the message buffer that arrives while the block's own send is still waiting for grant and ready. Reaching it needs the host port and the bus side driven together. The bench starts a send, then opens a write to byte 0 by hand and keeps it open while it plays the grant and ready handshake cycle by cycle. At each cycle it checks that the write stays stalled and that the new byte lands only after the bus is released. A full-queue overflow is reached by filling all four entries before a fifth matching message arrives. The bench then checks that the flag clears on the read and that the queued order is intact.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

    localparam int BYTE_W    = 8;
    localparam int MSG_BYTES = 4;
    localparam int MSG_W     = BYTE_W * MSG_BYTES;
    localparam int REG_AW    = 3;
    localparam int IDX_W     = $clog2(MSG_BYTES);

    // register decode points that the host sequencer depends on
    localparam logic [REG_AW-1:0] RA_TX_LAST = 3'd3;
    localparam logic [REG_AW-1:0] RA_RX_DATA = 3'd4;
    localparam logic [REG_AW-1:0] RA_STATUS  = 3'd5;
    localparam logic [REG_AW-1:0] RA_OWN     = 3'd6;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_REQ,
        TX_ADR,
        TX_DAT
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_DATA
    } rx_state_e;

    typedef struct packed {
        logic [MSG_BYTES-1:0][BYTE_W-1:0] tx;
        logic [BYTE_W-1:0]                own;
        logic [BYTE_W-1:0]                rdata;
        logic [IDX_W-1:0]                 ridx;
        logic                             ovf;
        logic                             done;
    } host_state_t;

    typedef struct packed {
        tx_state_e tx;
        rx_state_e rx;
    } eng_state_t;

endpackage

// File: rtl/mic_rx_queue.sv
module mic_rx_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } q_state_t;

    q_state_t q_q, q_d;
    logic     push_ok;
    logic     pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        q_d     = q_q;
        push_ok = push && (q_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (q_q.cnt != '0);
        if (push_ok) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = ptr_next(q_q.wr);
        end
        if (pop_ok) begin
            q_d.rd = ptr_next(q_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + CNT_W'(1);
            2'b01:   q_d.cnt = q_q.cnt - CNT_W'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head  = q_q.mem[q_q.rd];
    assign count = q_q.cnt;
    assign full  = (q_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/mic_host_port.sv
module mic_host_port
    import msg_irq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic                  rd_n,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  tx_busy,
    input  logic [CNT_W-1:0]      q_count,
    input  logic [MSG_W-1:0]      q_head,
    input  logic                  ovf_set,
    output logic [BYTE_W-1:0]     rdata,
    output logic                  wait_n,
    output logic [MSG_W-1:0]      tx_msg,
    output logic                  tx_launch,
    output logic [BYTE_W-1:0]     own_addr,
    output logic                  q_pop
);

    host_state_t q_q, q_d;

    logic              active;
    logic              is_wr;
    logic              stall;
    logic              fire;
    logic [BYTE_W-1:0] status;

    always_comb begin
        status                = '0;
        status[CNT_W-1:0]     = q_count;
        status[CNT_W]         = tx_busy;
        status[CNT_W+1]       = q_q.ovf;
    end

    always_comb begin
        q_d       = q_q;
        tx_launch = 1'b0;
        q_pop     = 1'b0;

        active = !cs_n && (!wr_n || !rd_n);
        is_wr  = !wr_n;
        stall  = is_wr && (reg_addr <= RA_TX_LAST) && tx_busy;
        fire   = active && !q_q.done && !stall;

        q_d.done = active && (q_q.done || fire);

        if (fire && is_wr) begin
            if (reg_addr <= RA_TX_LAST) begin
                q_d.tx[reg_addr[IDX_W-1:0]] = wdata;
                tx_launch = (reg_addr == RA_TX_LAST);
            end else if (reg_addr == RA_OWN) begin
                q_d.own = wdata;
            end
        end

        if (fire && !is_wr) begin
            if (reg_addr <= RA_TX_LAST) begin
                q_d.rdata = q_q.tx[reg_addr[IDX_W-1:0]];
            end else if (reg_addr == RA_RX_DATA) begin
                if (q_count != '0) begin
                    q_d.rdata = q_head[int'(q_q.ridx) * BYTE_W +: BYTE_W];
                    if (q_q.ridx == IDX_W'(MSG_BYTES - 1)) begin
                        q_d.ridx = '0;
                        q_pop    = 1'b1;
                    end else begin
                        q_d.ridx = q_q.ridx + IDX_W'(1);
                    end
                end else begin
                    q_d.rdata = '0;
                end
            end else if (reg_addr == RA_STATUS) begin
                q_d.rdata = status;
                q_d.ovf   = 1'b0;
            end else if (reg_addr == RA_OWN) begin
                q_d.rdata = q_q.own;
            end else begin
                q_d.rdata = '0;
            end
        end

        // a loss in the same cycle as the clearing read must survive
        if (ovf_set) begin
            q_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign rdata    = q_q.rdata;
    assign wait_n   = !(active && !q_q.done);
    assign tx_msg   = q_q.tx;
    assign own_addr = q_q.own;

endmodule

// File: rtl/mic_bus_engine.sv
module mic_bus_engine
    import msg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_launch,
    input  logic [MSG_W-1:0]  tx_msg,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              q_full,
    input  logic [MSG_W-1:0]  ad_in,
    input  logic              adr_strb_in,
    input  logic              dat_strb_in,
    input  logic              bus_gnt,
    input  logic              bus_rdy,
    output logic              bus_req,
    output logic              bus_sel,
    output logic [MSG_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic              adr_strb_out,
    output logic              dat_strb_out,
    output logic              tx_busy,
    output logic              q_push,
    output logic [MSG_W-1:0]  push_data,
    output logic              ovf_set
);

    localparam int PAD_W = MSG_W - BYTE_W;

    eng_state_t q_q, q_d;
    logic       addr_hit;

    always_comb begin
        q_d      = q_q;
        q_push   = 1'b0;
        ovf_set  = 1'b0;
        addr_hit = adr_strb_in && (ad_in == {{PAD_W{1'b0}}, own_addr});

        case (q_q.tx)
            TX_IDLE: if (tx_launch) q_d.tx = TX_REQ;
            TX_REQ:  if (bus_gnt)   q_d.tx = TX_ADR;
            TX_ADR:                 q_d.tx = TX_DAT;
            TX_DAT:  if (bus_rdy)   q_d.tx = TX_IDLE;
            default:                q_d.tx = TX_IDLE;
        endcase

        case (q_q.rx)
            RX_IDLE: begin
                if (addr_hit) begin
                    if (q_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        q_d.rx = RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (dat_strb_in) begin
                    q_push = 1'b1;
                    q_d.rx = RX_IDLE;
                end
            end
            default: q_d.rx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '{tx: TX_IDLE, rx: RX_IDLE};
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        ad_out = '0;
        case (q_q.tx)
            TX_ADR:  ad_out = {{PAD_W{1'b0}}, tx_msg[2*BYTE_W-1:BYTE_W]};
            TX_DAT:  ad_out = tx_msg;
            default: ad_out = '0;
        endcase
    end

    assign tx_busy      = (q_q.tx != TX_IDLE);
    assign bus_req      = (q_q.tx != TX_IDLE);
    assign ad_oe        = (q_q.tx == TX_ADR) || (q_q.tx == TX_DAT);
    assign adr_strb_out = (q_q.tx == TX_ADR);
    assign dat_strb_out = (q_q.tx == TX_DAT);
    assign bus_sel      = (q_q.rx == RX_DATA);
    assign push_data    = ad_in;

endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
    import msg_irq_pkg::*;
#(
    parameter int QDEPTH = 4,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              wait_n,
    output logic              msg_irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_rdy,
    output logic              bus_sel,
    input  logic [31:0]       ad_in,
    input  logic              adr_strb_in,
    input  logic              dat_strb_in,
    output logic [31:0]       ad_out,
    output logic              ad_oe,
    output logic              adr_strb_out,
    output logic              dat_strb_out
);

    logic [MSG_W-1:0]  tx_msg;
    logic              tx_launch;
    logic [BYTE_W-1:0] own_addr;
    logic              q_pop;
    logic              q_push;
    logic [MSG_W-1:0]  push_data;
    logic              q_full;
    logic [CNT_W-1:0]  q_count;
    logic [MSG_W-1:0]  q_head;
    logic              ovf_set;
    logic              tx_busy;

    mic_host_port #(.CNT_W(CNT_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .tx_busy   (tx_busy),
        .q_count   (q_count),
        .q_head    (q_head),
        .ovf_set   (ovf_set),
        .rdata     (rdata),
        .wait_n    (wait_n),
        .tx_msg    (tx_msg),
        .tx_launch (tx_launch),
        .own_addr  (own_addr),
        .q_pop     (q_pop)
    );

    mic_bus_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_launch    (tx_launch),
        .tx_msg       (tx_msg),
        .own_addr     (own_addr),
        .q_full       (q_full),
        .ad_in        (ad_in),
        .adr_strb_in  (adr_strb_in),
        .dat_strb_in  (dat_strb_in),
        .bus_gnt      (bus_gnt),
        .bus_rdy      (bus_rdy),
        .bus_req      (bus_req),
        .bus_sel      (bus_sel),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .adr_strb_out (adr_strb_out),
        .dat_strb_out (dat_strb_out),
        .tx_busy      (tx_busy),
        .q_push       (q_push),
        .push_data    (push_data),
        .ovf_set      (ovf_set)
    );

    mic_rx_queue #(.DEPTH(QDEPTH), .WIDTH(MSG_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (push_data),
        .pop       (q_pop),
        .head      (q_head),
        .count     (q_count),
        .full      (q_full)
    );

    assign msg_irq = (q_count != '0);

endmodule

// File: rtl/msg_irq_checker.sv
module msg_irq_checker #(
    parameter int QDEPTH = 4,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_rdy,
    input logic             bus_sel,
    input logic             ad_oe,
    input logic [31:0]      ad_out,
    input logic             adr_strb_out,
    input logic             dat_strb_out,
    input logic             dat_strb_in,
    input logic             msg_irq,
    input logic             q_push,
    input logic             q_full,
    input logic             ovf_set,
    input logic [CNT_W-1:0] q_count
);

    // R2: request is kept up without any bus phase until the grant arrives
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !ad_oe && !bus_gnt) |=> (bus_req && !ad_oe));

    // R2: address phase is always followed by the data phase
    a_r2_adr_then_dat: assert property (@(posedge clk) disable iff (!rst_n)
        adr_strb_out |=> (dat_strb_out && ad_oe));

    // R2: data phase and its word hold until ready
    a_r2_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_strb_out && !bus_rdy) |=> (dat_strb_out && $stable(ad_out)));

    // R5: select stays up until the data phase comes in
    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !dat_strb_in) |=> bus_sel);

    // R8: a stored message raises the interrupt
    a_r8_irq_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> msg_irq);

    // R9: nothing is captured into a full queue
    a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !q_full);

    // R9: loss is flagged only when the queue is full
    a_r9_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |-> (q_full && !bus_sel));

    // R7: fill never exceeds the queue depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

endmodule

bind msg_irq_ctrl msg_irq_checker #(.QDEPTH(QDEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_rdy      (bus_rdy),
    .bus_sel      (bus_sel),
    .ad_oe        (ad_oe),
    .ad_out       (ad_out),
    .adr_strb_out (adr_strb_out),
    .dat_strb_out (dat_strb_out),
    .dat_strb_in  (dat_strb_in),
    .msg_irq      (msg_irq),
    .q_push       (q_push),
    .q_full       (q_full),
    .ovf_set      (ovf_set),
    .q_count      (q_count)
);

// File: tb/msg_irq_ctrl_test.sv
module msg_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        wait_n;
    logic        msg_irq;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_rdy = 1'b0;
    logic        bus_sel;
    logic [31:0] ad_in = '0;
    logic        adr_strb_in = 1'b0;
    logic        dat_strb_in = 1'b0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        adr_strb_out;
    logic        dat_strb_out;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0] last_rd;
    int         last_waits;
    logic       last_first;

    localparam logic [7:0]  OWN   = 8'h5A;
    localparam logic [31:0] OWN32 = 32'h0000005A;

    always #5 clk = ~clk;

    msg_irq_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .wr_n         (wr_n),
        .rd_n         (rd_n),
        .reg_addr     (reg_addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .wait_n       (wait_n),
        .msg_irq      (msg_irq),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .bus_rdy      (bus_rdy),
        .bus_sel      (bus_sel),
        .ad_in        (ad_in),
        .adr_strb_in  (adr_strb_in),
        .dat_strb_in  (dat_strb_in),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .adr_strb_out (adr_strb_out),
        .dat_strb_out (dat_strb_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        wdata    = d;
        cs_n     = 1'b0;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        #1 last_first = wait_n;
        last_waits = 0;
        @(negedge clk);
        while (!wait_n) begin
            last_waits++;
            @(negedge clk);
        end
        last_rd = rdata;
        cs_n = 1'b1;
        wr_n = 1'b1;
        rd_n = 1'b1;
    endtask

    task automatic rx_msg(input logic [31:0] a, input logic [31:0] d, output logic sel);
        @(negedge clk);
        ad_in       = a;
        adr_strb_in = 1'b1;
        @(negedge clk);
        sel         = bus_sel;
        adr_strb_in = 1'b0;
        ad_in       = d;
        dat_strb_in = 1'b1;
        @(negedge clk);
        dat_strb_in = 1'b0;
        ad_in       = '0;
    endtask

    function automatic logic [31:0] pat(input int n);
        return (32'h9E3779B9 * 32'(n + 1)) ^ 32'h00FF00FF;
    endfunction

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        end
    endtask

    initial begin
        #2_000_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic        sel;
        logic [31:0] w;
        logic [7:0]  b [4];

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 wait_n", 32'(wait_n), 1);
        chk("R11 msg_irq", 32'(msg_irq), 0);
        chk("R11 bus_req", 32'(bus_req), 0);
        chk("R11 bus_sel", 32'(bus_sel), 0);
        chk("R11 ad_oe", 32'(ad_oe), 0);
        chk("R11 strobes", 32'({adr_strb_out, dat_strb_out}), 0);
        acc(0, 3'd5, 8'h00);
        chk("R11 status", 32'(last_rd), 0);
        acc(0, 3'd6, 8'h00);
        chk("R11 own address", 32'(last_rd), 0);

        // R10 and R3
        acc(1, 3'd6, OWN);
        chk("R3 wait low at start", 32'(last_first), 0);
        chk("R3 no extra waits", last_waits, 0);
        acc(0, 3'd6, 8'h00);
        chk("R10 own readback", 32'(last_rd), 32'(OWN));
        acc(1, 3'd7, 8'hFF);
        acc(0, 3'd7, 8'h00);
        chk("R10 reg7 reads zero", 32'(last_rd), 0);
        acc(0, 3'd6, 8'h00);
        chk("R10 own unchanged by reg7", 32'(last_rd), 32'(OWN));

        // R6 single-bit address mismatches
        for (int i = 0; i < 32; i++) begin
            rx_msg(OWN32 ^ (32'd1 << i), 32'hCAFE0000 + 32'(i), sel);
            chk("R6 no select on mismatch", 32'(sel), 0);
        end
        acc(0, 3'd5, 8'h00);
        chk("R6 queue still empty", 32'(last_rd), 0);
        chk("R6 irq low", 32'(msg_irq), 0);

        // R5 R7 R8 fill levels 1..4 and full drain
        for (int n = 1; n <= 4; n++) begin
            for (int m = 0; m < n; m++) begin
                rx_msg(OWN32, pat(10 * n + m), sel);
                chk("R5 select on match", 32'(sel), 1);
                chk("R5 select drops after data", 32'(bus_sel), 0);
                chk("R8 irq with message", 32'(msg_irq), 1);
                acc(0, 3'd5, 8'h00);
                chk("R9 status count", 32'(last_rd), 32'(m + 1));
            end
            for (int m = 0; m < n; m++) begin
                w = pat(10 * n + m);
                for (int k = 0; k < 4; k++) begin
                    acc(0, 3'd4, 8'h00);
                    chk("R7 byte order", 32'(last_rd), 32'(w[8*k +: 8]));
                end
                chk("R8 irq level after pop", 32'(msg_irq), 32'(m < n - 1));
            end
            acc(0, 3'd4, 8'h00);
            chk("R7 empty read zero", 32'(last_rd), 0);
            acc(0, 3'd5, 8'h00);
            chk("R7 empty read no change", 32'(last_rd), 0);
        end

        // R9 overflow
        for (int m = 0; m < 4; m++) begin
            rx_msg(OWN32, pat(100 + m), sel);
        end
        rx_msg(OWN32, 32'hDEADBEEF, sel);
        chk("R9 no select when full", 32'(sel), 0);
        acc(0, 3'd5, 8'h00);
        chk("R9 status full with overflow", 32'(last_rd), 32'h14);
        acc(0, 3'd5, 8'h00);
        chk("R9 overflow cleared by read", 32'(last_rd), 32'h04);
        for (int m = 0; m < 4; m++) begin
            w = pat(100 + m);
            for (int k = 0; k < 4; k++) begin
                acc(0, 3'd4, 8'h00);
                chk("R9 stored order kept", 32'(last_rd), 32'(w[8*k +: 8]));
            end
        end
        chk("R8 irq low when drained", 32'(msg_irq), 0);

        // R1 R2 transmit sequences
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 4; i++) b[i] = 8'(t * 37 + i * 11 + 3);
            w = {b[3], b[2], b[1], b[0]};
            for (int i = 0; i < 3; i++) acc(1, 3'(i), b[i]);
            chk("R1 no request before last byte", 32'(bus_req), 0);
            acc(1, 3'd3, b[3]);
            chk("R1 request after last byte", 32'(bus_req), 1);
            for (int i = 0; i < 4; i++) begin
                acc(0, 3'(i), 8'h00);
                chk("R1 tx byte readback", 32'(last_rd), 32'(b[i]));
            end
            acc(0, 3'd5, 8'h00);
            chk("R9 status busy bit", 32'(last_rd), 32'h08);
            for (int c = 0; c <= t; c++) begin
                @(negedge clk);
                chk("R2 request held", 32'(bus_req), 1);
                chk("R2 no phase before grant", 32'({ad_oe, adr_strb_out}), 0);
            end
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            chk("R2 address phase", 32'({adr_strb_out, ad_oe, dat_strb_out}), 32'b110);
            chk("R2 address value", ad_out, 32'(b[1]));
            @(negedge clk);
            chk("R2 data phase", 32'({dat_strb_out, ad_oe, adr_strb_out}), 32'b110);
            chk("R2 data value", ad_out, w);
            for (int c = 0; c < t; c++) begin
                @(negedge clk);
                chk("R2 data held", ad_out, w);
                chk("R2 data strobe held", 32'(dat_strb_out), 1);
            end
            bus_rdy = 1'b1;
            @(negedge clk);
            bus_rdy = 1'b0;
            chk("R2 bus released", 32'({bus_req, ad_oe, adr_strb_out, dat_strb_out}), 0);
        end

        // R4 write stalled during a send
        for (int i = 0; i < 4; i++) acc(1, 3'(i), 8'(8'hA0 + i));
        @(negedge clk);
        reg_addr = 3'd0;
        wdata    = 8'h77;
        cs_n     = 1'b0;
        wr_n     = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R4 stalled while waiting for grant", 32'(wait_n), 0);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R4 stalled in address phase", 32'(wait_n), 0);
        @(negedge clk);
        chk("R4 stalled in data phase", 32'(wait_n), 0);
        chk("R4 original byte sent", ad_out, 32'hA3A2A1A0);
        bus_rdy = 1'b1;
        @(negedge clk);
        bus_rdy = 1'b0;
        chk("R4 still waiting at release", 32'(wait_n), 0);
        chk("R4 bus released", 32'(bus_req), 0);
        @(negedge clk);
        chk("R4 write completes", 32'(wait_n), 1);
        cs_n = 1'b1;
        wr_n = 1'b1;
        acc(0, 3'd0, 8'h00);
        chk("R4 stalled write landed", 32'(last_rd), 32'h77);
        chk("R4 no new send", 32'(bus_req), 0);

        summary();
        $finish;
    end

endmodule